// File: doc/BRIEF.md
# Two-Wire Serial Synthesizer Register Loader

This block is a receive-only slave on a two-wire serial bus that loads the four 24-bit control registers of a dual frequency synthesizer: a reference divider register and a main divider register for each of the two loops. A host starts a transfer and sends an 8-bit device address, then a stream of data bytes. The block acknowledges each accepted byte by enabling an open-drain pull-down on the data line.

Every three data bytes form one 24-bit word. The two least significant bits of that word pick the destination register. The word is written as soon as its third byte has been shifted in; no stop condition is needed for the write. The expected device address comes from a 2-bit select code, which in a system would be produced by an external voltage-level decoder.

Both bus lines are oversampled by the system clock through a synchronizer. All edge and condition detection works on the synchronized copies.

Top module: `pll_serial_loader`

## Requirements
- R1: After reset all four register outputs are zero and the acknowledge drive `dat_oe_o` is low.
- R2: A start condition (data falling while the bus clock is high) begins a new transfer whose first byte is the address. A start also clears the count of data bytes within the current word.
- R3: The address byte is received most significant bit first and compared as a full 8-bit value with the code selected by `addr_sel_i`: 00 gives 0xC2, 01 gives 0xC0, 10 gives 0xC4, 11 gives 0xC6. On a match the block pulls data low during the ninth clock pulse.
- R4: On an address mismatch there is no acknowledge. Every later byte up to the next start is neither acknowledged nor written.
- R5: Each data byte of an addressed transfer is acknowledged. The drive is enabled after the bus-clock falling edge that ends the eighth bit and is released on the falling edge that ends the acknowledge pulse.
- R6: Three consecutive data bytes form one word, with the first byte in bits 23:16 and the third byte in bits 7:0. The word is written right after the third byte, before any stop.
- R7: Word bits 1:0 select the destination: 00 loop-2 reference, 01 loop-2 main, 10 loop-1 reference, 11 loop-1 main. The full 24-bit word is stored, and the other three registers keep their values.
- R8: One transfer may carry several words back to back, and each one is written in turn.
- R9: A start or stop that arrives part-way through a 3-byte group discards the partial word. The next group starts again with the first byte.
- R10: After a stop the block gives no acknowledge and writes nothing until a new start and a matching address arrive.
- R11: The acknowledge drive never changes while the synchronized bus clock is high, except on a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 10x the bus bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Serial bus clock line (asynchronous) |
| bus_dat_i | input | 1 | Serial bus data line as seen on the wire (asynchronous) |
| addr_sel_i | input | 2 | Device address select code |
| dat_oe_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| pll2_ref_o | output | 24 | Loop-2 reference divider register (select 00) |
| pll2_main_o | output | 24 | Loop-2 main divider register (select 01) |
| pll1_ref_o | output | 24 | Loop-1 reference divider register (select 10) |
| pll1_main_o | output | 24 | Loop-1 main divider register (select 11) |

## Verification
Two functions can fall together. The commit of a completed word coincides with the acknowledge of its third byte, and a bus condition can land while a partial word is held. The bench provokes the first case by reading all four registers in the low phase right after the third byte's acknowledge, with no stop yet sent. That read must show the new word while the acknowledge was still seen. It provokes the second case with a stop after two bytes and a repeated start after one byte. A correct result is that no register moves from the partial data, and the group that follows the repeated start lands intact.

// File: rtl/pll_ldr_pkg.sv
package pll_ldr_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 4;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_SHIFT,
    RX_DECIDE,
    RX_ACK,
    RX_IGNORE
  } rx_state_e;

  function automatic logic [BYTE_W-1:0] addr_for_sel(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8'hC2;
      2'b01:   return 8'hC0;
      2'b10:   return 8'hC4;
      default: return 8'hC6;
    endcase
  endfunction
endpackage

// File: rtl/pll_ldr_line_sync.sv
module pll_ldr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_clk_i,
  input  logic bus_dat_i,
  output logic dat_s_o,
  output logic clk_hi_o,
  output logic clk_rise_o,
  output logic clk_fall_o,
  output logic start_o,
  output logic stop_o
);
  // index 0 = bus clock, 1 = bus data
  logic [1:0] ff_q [STAGES];
  logic [1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q[0] <= 2'b11;
    else         ff_q[0] <= {bus_dat_i, bus_clk_i};
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q[s] <= 2'b11;
      else         ff_q[s] <= ff_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 2'b11;
    else         prev_q <= ff_q[STAGES-1];
  end

  logic c_now, c_old, d_now, d_old;
  assign c_now = ff_q[STAGES-1][0];
  assign d_now = ff_q[STAGES-1][1];
  assign c_old = prev_q[0];
  assign d_old = prev_q[1];

  assign dat_s_o    = d_now;
  assign clk_hi_o   = c_now & c_old;
  assign clk_rise_o = c_now & ~c_old;
  assign clk_fall_o = ~c_now & c_old;
  assign start_o    = c_now & c_old & d_old & ~d_now;
  assign stop_o     = c_now & c_old & ~d_old & d_now;

  // R2: bus conditions and clock edges are mutually exclusive per cycle
  p_cond_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, stop_o, clk_rise_o, clk_fall_o}));
endmodule

// File: rtl/pll_ldr_byte_rx.sv
module pll_ldr_byte_rx
  import pll_ldr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_sel_i,
  input  logic              dat_s_i,
  input  logic              clk_hi_i,
  input  logic              clk_rise_i,
  input  logic              clk_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              data_stb_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              oe_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              is_addr_q;
  logic              oe_q;
  logic              stb_q;
  logic              addr_ok;

  assign addr_ok = (shreg_q == addr_for_sel(addr_sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      is_addr_q <= 1'b0;
      oe_q      <= 1'b0;
      stb_q     <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (start_i) begin
        state_q   <= RX_SHIFT;
        bit_cnt_q <= '0;
        is_addr_q <= 1'b1;
        oe_q      <= 1'b0;
      end else if (stop_i) begin
        state_q <= RX_IDLE;
        oe_q    <= 1'b0;
      end else begin
        case (state_q)
          RX_SHIFT: if (clk_rise_i) begin
            shreg_q   <= {shreg_q[BYTE_W-2:0], dat_s_i};
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == CNT_W'(BYTE_W-1)) begin
              state_q <= RX_DECIDE;
              stb_q   <= ~is_addr_q;
            end
          end
          RX_DECIDE: if (clk_fall_i) begin
            if (is_addr_q && !addr_ok) begin
              state_q <= RX_IGNORE;
            end else begin
              state_q <= RX_ACK;
              oe_q    <= 1'b1;
            end
          end
          RX_ACK: if (clk_fall_i) begin
            oe_q      <= 1'b0;
            is_addr_q <= 1'b0;
            bit_cnt_q <= '0;
            state_q   <= RX_SHIFT;
          end
          default: ;
        endcase
      end
    end
  end

  assign data_stb_o = stb_q;
  assign data_o     = shreg_q;
  assign oe_o       = oe_q;

  p_oe_steady_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_hi_i && !start_i && !stop_i) |=> $stable(oe_q));
  p_stop_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!oe_q && state_q == RX_IDLE));
  p_ack_low_phase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !clk_rise_i && $past(clk_fall_i));
  p_mismatch_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_IGNORE) |-> !oe_q && !stb_q);
endmodule

// File: rtl/pll_ldr_word_asm.sv
module pll_ldr_word_asm
  import pll_ldr_pkg::*;
#(
  parameter int BYTES_PER_WORD = 3,
  localparam int WORD_W = BYTE_W * BYTES_PER_WORD
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             clr_i,
  input  logic                             data_stb_i,
  input  logic [BYTE_W-1:0]                data_i,
  output logic [NUM_REGS-1:0][WORD_W-1:0]  regs_o
);
  localparam int ACC_W = WORD_W - BYTE_W;
  localparam int GRP_W = $clog2(BYTES_PER_WORD);
  localparam int SEL_W = $clog2(NUM_REGS);

  logic [GRP_W-1:0]  grp_q;
  logic [ACC_W-1:0]  acc_q;
  logic              commit;
  logic [WORD_W-1:0] word;

  assign commit = data_stb_i && (grp_q == GRP_W'(BYTES_PER_WORD-1));
  assign word   = {acc_q, data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q <= '0;
      acc_q <= '0;
    end else if (clr_i) begin
      grp_q <= '0;
    end else if (data_stb_i) begin
      if (commit) begin
        grp_q <= '0;
      end else begin
        grp_q <= grp_q + 1'b1;
        acc_q <= (acc_q << BYTE_W) | ACC_W'(data_i);
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_o[g] <= '0;
      else if (commit && word[SEL_W-1:0] == SEL_W'(g)) regs_o[g] <= word;
    end

    p_write_on_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (regs_o[g] != $past(regs_o[g])) |-> $past(data_stb_i) && !$past(clr_i));
    p_sel_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (regs_o[g] != $past(regs_o[g])) |-> regs_o[g][SEL_W-1:0] == SEL_W'(g));
  end

  p_grp_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_q < GRP_W'(BYTES_PER_WORD));
  p_clr_group_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> grp_q == '0);
endmodule

// File: rtl/pll_serial_loader.sv
module pll_serial_loader
  import pll_ldr_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int BYTES_PER_WORD = 3,
  localparam int WORD_W = BYTE_W * BYTES_PER_WORD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_clk_i,
  input  logic              bus_dat_i,
  input  logic [1:0]        addr_sel_i,
  output logic              dat_oe_o,
  output logic [WORD_W-1:0] pll2_ref_o,
  output logic [WORD_W-1:0] pll2_main_o,
  output logic [WORD_W-1:0] pll1_ref_o,
  output logic [WORD_W-1:0] pll1_main_o
);
  logic dat_s, clk_hi, clk_rise, clk_fall, start, stop;
  logic data_stb;
  logic [BYTE_W-1:0] data_byte;
  logic [NUM_REGS-1:0][WORD_W-1:0] regs;

  pll_ldr_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_clk_i  (bus_clk_i),
    .bus_dat_i  (bus_dat_i),
    .dat_s_o    (dat_s),
    .clk_hi_o   (clk_hi),
    .clk_rise_o (clk_rise),
    .clk_fall_o (clk_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  pll_ldr_byte_rx i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_sel_i (addr_sel_i),
    .dat_s_i    (dat_s),
    .clk_hi_i   (clk_hi),
    .clk_rise_i (clk_rise),
    .clk_fall_i (clk_fall),
    .start_i    (start),
    .stop_i     (stop),
    .data_stb_o (data_stb),
    .data_o     (data_byte),
    .oe_o       (dat_oe_o)
  );

  pll_ldr_word_asm #(.BYTES_PER_WORD(BYTES_PER_WORD)) i_asm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start | stop),
    .data_stb_i (data_stb),
    .data_i     (data_byte),
    .regs_o     (regs)
  );

  assign pll2_ref_o  = regs[0];
  assign pll2_main_o = regs[1];
  assign pll1_ref_o  = regs[2];
  assign pll1_main_o = regs[3];

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dat_oe_o) |-> !start && !stop);
endmodule

// File: tb/test_pll_serial_loader.sv
module test_pll_serial_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] sel = 2'b00;
  logic oe;
  logic sda_line;
  logic [23:0] r0, r1, r2, r3;
  logic [23:0] model [4];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~oe;

  pll_serial_loader i_pll_serial_loader (
    .clk_i(clk), .rst_ni(rst_n), .bus_clk_i(scl_m), .bus_dat_i(sda_line),
    .addr_sel_i(sel), .dat_oe_o(oe),
    .pll2_ref_o(r0), .pll2_main_o(r1), .pll1_ref_o(r2), .pll1_main_o(r3)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] rd(input int i);
    case (i)
      0: return r0;
      1: return r1;
      2: return r2;
      default: return r3;
    endcase
  endfunction

  task automatic chk_regs(input string tag);
    for (int i = 0; i < 4; i++)
      chk(rd(i) == model[i], tag, 32'(rd(i)), 32'(model[i]));
  endtask

  function automatic logic [7:0] exp_addr(input logic [1:0] s);
    case (s)
      2'b00: return 8'hC2;
      2'b01: return 8'hC0;
      2'b10: return 8'hC4;
      default: return 8'hC6;
    endcase
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wt(10);
    sda_m = 1'b0; wt(10);
    scl_m = 1'b0;
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wt(4);
    scl_m = 1'b1; wt(10);
    sda_m = 1'b0; wt(10);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(5);
    scl_m = 1'b1; wt(10);
    sda_m = 1'b1; wt(20);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack, output bit rel);
    for (int i = 7; i >= 0; i--) begin
      wt(5); sda_m = b[i];
      wt(5); scl_m = 1'b1;
      wt(10); scl_m = 1'b0;
    end
    wt(5); sda_m = 1'b1;
    wt(5); scl_m = 1'b1;
    wt(5); ack = !sda_line;
    wt(5); scl_m = 1'b0;
    wt(6); rel = !oe;
  endtask

  task automatic send_word(input logic [23:0] w, input bit exp_ack, input string tag);
    bit a, r;
    for (int k = 0; k < 3; k++) begin
      send_byte(w[23-8*k -: 8], a, r);
      chk(a == exp_ack, tag, 32'(a), 32'(exp_ack));
      chk(r, "R5 release", 32'(r), 1);
    end
  endtask

  initial begin
    bit a, r;
    logic [7:0] cands [6];
    logic [23:0] w;
    cands = '{8'hC0, 8'hC2, 8'hC4, 8'hC6, 8'hC3, 8'h46};
    for (int i = 0; i < 4; i++) model[i] = '0;
    wt(5); rst_n = 1'b1; wt(5);
    chk_regs("R1 reset regs");
    chk(oe == 1'b0, "R1 reset oe", 32'(oe), 0);

    // sweep: every select code against every candidate address
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 6; c++) begin
        bit hit;
        int k;
        logic [1:0] tgt;
        sel = 2'(s);
        k = s * 6 + c;
        tgt = 2'((s + c) % 4);
        hit = (cands[c] == exp_addr(2'(s)));
        w = {8'(k * 29 + 17), 8'(k * 7) ^ 8'(s), 6'(k), tgt};
        wt(10);
        bus_start();
        send_byte(cands[c], a, r);
        chk(a == hit, hit ? "R3 addr ack" : "R4 addr nack", 32'(a), 32'(hit));
        send_word(w, hit, hit ? "R5 data ack" : "R4 data ignored");
        if (hit) model[tgt] = w;
        chk_regs(hit ? "R6 R7 commit before stop" : "R4 no write");
        bus_stop();
      end
    end

    sel = 2'b11;
    // R8: two words in one transfer, first visible before the second ends
    bus_start();
    send_byte(8'hC6, a, r);
    chk(a, "R3 addr ack", 32'(a), 1);
    w = 24'hA5_3C_F0; send_word(w, 1'b1, "R8 ack");
    model[0] = w; chk_regs("R8 first word");
    w = 24'h12_34_55; send_word(w, 1'b1, "R8 ack");
    model[1] = w; chk_regs("R8 second word");
    bus_stop();

    // R9: stop after two bytes discards the partial word
    bus_start();
    send_byte(8'hC6, a, r);
    send_byte(8'h77, a, r);
    send_byte(8'h66, a, r);
    bus_stop();
    chk_regs("R9 stop discards");
    // R9 / R2: repeated start after one byte, then a clean group
    bus_start();
    send_byte(8'hC6, a, r);
    send_byte(8'hEE, a, r);
    bus_rstart();
    send_byte(8'hC6, a, r);
    chk(a, "R2 restart addr ack", 32'(a), 1);
    w = 24'h0F_1E_2E; send_word(w, 1'b1, "R9 ack");
    model[2] = w; chk_regs("R9 restart group");
    bus_stop();

    // R10: bits after stop without a start get no ack and write nothing
    scl_m = 1'b0; wt(10);
    send_byte(8'hC6, a, r);
    chk(!a, "R10 no ack after stop", 32'(a), 0);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'hFF, a, r);
      chk(!a, "R10 no data ack", 32'(a), 0);
    end
    chk_regs("R10 no write");
    sda_m = 1'b1; wt(5); scl_m = 1'b1; wt(10);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule